// File: doc/BRIEF.md
# AXI4 Write Burst Master

The block turns one command at a time into a single AXI4 INCR write burst. A command carries a start byte address, a beat count minus one and a transfer size given as log2 of the bytes per beat. After a command is taken, the block offers the write address and the first write data beat together. It does not wait for either ready. The data and strobes for each beat come from the block itself, and the block then collects the write response. Only then does it take the next command.

Beat data is a running count of accepted beats. The byte strobes follow the beat address. The first beat of an unaligned burst enables only the lanes from the start byte to the next size boundary. Each later beat enables the full aligned window at the incremented address, taken modulo the bus width. A command whose address does not fit the AXI address width, or whose size exceeds the bus width, is consumed and dropped. A non-OKAY write response sets a sticky error flag.

Top module: `axi_wr_burst_master`

## Requirements
- R1: After reset, m_awvalid_o, m_wvalid_o, m_bready_o and err_o are 0 and cmd_ready_o is 1.
- R2: cmd_ready_o is 1 only when no address, data or response transfer is outstanding.
- R3: One cycle after an accepted legal command, m_awvalid_o and m_wvalid_o are both 1 with no dependence on either ready. m_awaddr_o, m_awlen_o and m_awsize_o equal the command fields, and m_awburst_o is 2'b01 (INCR).
- R4: While m_awvalid_o is 1 and m_awready_i is 0, on the next cycle m_awvalid_o stays 1 and the address payload is unchanged.
- R5: While m_wvalid_o is 1 and m_wready_i is 0, on the next cycle m_wvalid_o stays 1 and m_wdata_o, m_wstrb_o and m_wlast_o are unchanged.
- R6: Exactly len+1 beats are accepted per burst. m_wlast_o is 1 only on beat number len, and m_wvalid_o is 0 in the cycle after that beat is accepted.
- R7: Bit i of m_wstrb_o enables byte lane i. For beat k, with A = start address rounded down to a multiple of 2^size, the lanes are (A + k*2^size) mod STRB_W up to that value plus 2^size-1. On beat 0 the lower bound is instead start mod STRB_W.
- R8: m_wdata_o of each beat equals the number of beats accepted since reset, zero-extended.
- R9: m_bready_o is 1 exactly while the address and all data beats have been accepted and the response is pending. A response handshake returns the block to idle.
- R10: A response with m_bresp_i not equal to 2'b00 sets err_o. err_o then stays 1 until reset, including after later OKAY responses.
- R11: A command whose address bits at or above ADDR_W are nonzero, or whose size exceeds log2(STRB_W), is consumed. No m_awvalid_o or m_wvalid_o follows, and cmd_ready_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle, command taken |
| cmd_addr_i | input | CMD_ADDR_W | Start byte address |
| cmd_len_i | input | LEN_W | Beats minus one |
| cmd_size_i | input | 3 | log2 bytes per beat |
| m_awvalid_o | output | 1 | Address valid |
| m_awready_i | input | 1 | Address ready |
| m_awaddr_o | output | ADDR_W | Burst start address |
| m_awlen_o | output | LEN_W | Burst length minus one |
| m_awsize_o | output | 3 | Beat size code |
| m_awburst_o | output | 2 | Burst type, always INCR |
| m_wvalid_o | output | 1 | Data valid |
| m_wready_i | input | 1 | Data ready |
| m_wdata_o | output | DATA_W | Beat data |
| m_wstrb_o | output | STRB_W | Byte lane enables |
| m_wlast_o | output | 1 | Final beat marker |
| m_bvalid_i | input | 1 | Response valid |
| m_bready_o | output | 1 | Response ready |
| m_bresp_i | input | 2 | Response code |
| err_o | output | 1 | Sticky error response flag |

## Verification
Some properties are checked on every cycle: the hold rules on both valid channels, the idle-only command ready, nonzero strobes that never exceed the beat size, the drop of data valid after the last beat, rejection of illegal commands and the sticky error. Other results only the directed scenarios can show. These are the exact lane pattern of each beat across unaligned starts and every size, the beat count and data sequence, the timing of response ready, and clearing of the error by reset. The slave model stalls both readies pseudo-randomly, so data beats arrive ahead of, with and after the address handshake.

// File: rtl/axi_wr_pkg.sv
package axi_wr_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} wr_state_e;
  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;
endpackage

// File: rtl/awb_lane_mask.sv
module awb_lane_mask #(
  parameter int STRB_W = 4,
  localparam int LANE_W = (STRB_W > 1) ? $clog2(STRB_W) : 1
) (
  input  logic [LANE_W-1:0] lane_i,
  input  logic [2:0]        size_i,
  output logic [STRB_W-1:0] strb_o
);
  logic [LANE_W-1:0] sz_mask;
  logic [LANE_W-1:0] hi;

  assign sz_mask = LANE_W'((32'd1 << size_i) - 32'd1);
  // upper lane is end of the size-aligned window holding lane_i
  assign hi      = lane_i | sz_mask;

  for (genvar i = 0; i < STRB_W; i++) begin : g_lane
    assign strb_o[i] = (LANE_W'(i) >= lane_i) && (LANE_W'(i) <= hi);
  end
endmodule

// File: rtl/awb_wr_data.sv
module awb_wr_data #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  localparam int STRB_W = DATA_W / 8,
  localparam int LANE_W = (STRB_W > 1) ? $clog2(STRB_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [2:0]        size_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              wready_i,
  output logic              wvalid_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [STRB_W-1:0] wstrb_o,
  output logic              wlast_o,
  output logic              done_o
);
  logic              wvalid_q, done_q;
  logic [LEN_W-1:0]  beat_q, len_q;
  logic [LANE_W-1:0] lane_q;
  logic [2:0]        size_q;
  logic [DATA_W-1:0] pat_q;
  logic              w_fire;
  logic [LANE_W-1:0] sz_mask;

  assign w_fire  = wvalid_q && wready_i;
  assign sz_mask = LANE_W'((32'd1 << size_q) - 32'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wvalid_q <= 1'b0;
      done_q   <= 1'b0;
      beat_q   <= '0;
      len_q    <= '0;
      lane_q   <= '0;
      size_q   <= '0;
      pat_q    <= '0;
    end else begin
      if (w_fire) pat_q <= pat_q + 1'b1;
      if (start_i) begin
        wvalid_q <= 1'b1;
        done_q   <= 1'b0;
        beat_q   <= '0;
        len_q    <= len_i;
        lane_q   <= lane_i;
        size_q   <= size_i;
      end else if (w_fire) begin
        if (wlast_o) begin
          wvalid_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          beat_q <= beat_q + 1'b1;
          lane_q <= (lane_q & ~sz_mask) + LANE_W'(32'd1 << size_q);
        end
      end
    end
  end

  awb_lane_mask #(.STRB_W(STRB_W)) lane_mask_i (
    .lane_i (lane_q),
    .size_i (size_q),
    .strb_o (wstrb_o)
  );

  assign wvalid_o = wvalid_q;
  assign wdata_o  = pat_q;
  assign wlast_o  = (beat_q == len_q);
  assign done_o   = done_q;

  a_r5_w_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wvalid_q && !wready_i |=> wvalid_q && $stable(wdata_o) && $stable(wstrb_o) && $stable(wlast_o));
  a_r6_drop_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_fire && wlast_o |=> !wvalid_q);
  a_r7_strb_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wvalid_q |-> (wstrb_o != '0) && ($countones(wstrb_o) <= (32'd1 << size_q)));
endmodule

// File: rtl/axi_wr_burst_master.sv
module axi_wr_burst_master
  import axi_wr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CMD_ADDR_W = 40,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 8,
  localparam int STRB_W    = DATA_W / 8,
  localparam int LANE_W    = (STRB_W > 1) ? $clog2(STRB_W) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  output logic                  cmd_ready_o,
  input  logic [CMD_ADDR_W-1:0] cmd_addr_i,
  input  logic [LEN_W-1:0]      cmd_len_i,
  input  logic [2:0]            cmd_size_i,
  output logic                  m_awvalid_o,
  input  logic                  m_awready_i,
  output logic [ADDR_W-1:0]     m_awaddr_o,
  output logic [LEN_W-1:0]      m_awlen_o,
  output logic [2:0]            m_awsize_o,
  output logic [1:0]            m_awburst_o,
  output logic                  m_wvalid_o,
  input  logic                  m_wready_i,
  output logic [DATA_W-1:0]     m_wdata_o,
  output logic [STRB_W-1:0]     m_wstrb_o,
  output logic                  m_wlast_o,
  input  logic                  m_bvalid_i,
  output logic                  m_bready_o,
  input  logic [1:0]            m_bresp_i,
  output logic                  err_o
);
  localparam logic [2:0] SIZE_MAX = 3'($clog2(STRB_W));

  wr_state_e         state_q;
  logic              awvalid_q, aw_done_q, err_q;
  logic [ADDR_W-1:0] awaddr_q;
  logic [LEN_W-1:0]  awlen_q;
  logic [2:0]        awsize_q;
  logic              cmd_fire, cmd_ok, start, b_fire, w_done;

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign cmd_fire    = cmd_valid_i && cmd_ready_o;
  assign cmd_ok      = (cmd_addr_i[CMD_ADDR_W-1:ADDR_W] == '0) && (cmd_size_i <= SIZE_MAX);
  assign start       = cmd_fire && cmd_ok;
  assign m_bready_o  = (state_q == ST_BUSY) && aw_done_q && w_done;
  assign b_fire      = m_bvalid_i && m_bready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      awvalid_q <= 1'b0;
      aw_done_q <= 1'b0;
      awaddr_q  <= '0;
      awlen_q   <= '0;
      awsize_q  <= '0;
      err_q     <= 1'b0;
    end else begin
      if (start) begin
        state_q   <= ST_BUSY;
        awvalid_q <= 1'b1;
        aw_done_q <= 1'b0;
        awaddr_q  <= cmd_addr_i[ADDR_W-1:0];
        awlen_q   <= cmd_len_i;
        awsize_q  <= cmd_size_i;
      end else if (awvalid_q && m_awready_i) begin
        awvalid_q <= 1'b0;
        aw_done_q <= 1'b1;
      end
      if (b_fire) begin
        state_q <= ST_IDLE;
        if (m_bresp_i != RESP_OKAY) err_q <= 1'b1;
      end
    end
  end

  awb_wr_data #(.DATA_W(DATA_W), .LEN_W(LEN_W)) wr_data_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .lane_i   (cmd_addr_i[LANE_W-1:0]),
    .size_i   (cmd_size_i),
    .len_i    (cmd_len_i),
    .wready_i (m_wready_i),
    .wvalid_o (m_wvalid_o),
    .wdata_o  (m_wdata_o),
    .wstrb_o  (m_wstrb_o),
    .wlast_o  (m_wlast_o),
    .done_o   (w_done)
  );

  assign m_awvalid_o = awvalid_q;
  assign m_awaddr_o  = awaddr_q;
  assign m_awlen_o   = awlen_q;
  assign m_awsize_o  = awsize_q;
  assign m_awburst_o = BURST_INCR;
  assign err_o       = err_q;

  a_r2_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !m_awvalid_o && !m_wvalid_o && !m_bready_o);
  a_r4_aw_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awvalid_q && !m_awready_i |=> awvalid_q && $stable(m_awaddr_o) && $stable(m_awlen_o) && $stable(m_awsize_o));
  a_r10_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_fire && (m_bresp_i != RESP_OKAY) |=> err_o);
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  a_r11_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_fire && !cmd_ok |=> cmd_ready_o && !m_awvalid_o && !m_wvalid_o);
endmodule

// File: tb/axi_wr_burst_master_tb_top.sv
module axi_wr_burst_master_tb_top;
  localparam int ADDR_W = 32, CMD_ADDR_W = 40, DATA_W = 32, LEN_W = 8, STRB_W = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [CMD_ADDR_W-1:0] cmd_addr = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [2:0] cmd_size = '0;
  logic awvalid, awready = 1'b0;
  logic [ADDR_W-1:0] awaddr;
  logic [LEN_W-1:0] awlen;
  logic [2:0] awsize;
  logic [1:0] awburst;
  logic wvalid, wready = 1'b0, wlast;
  logic [DATA_W-1:0] wdata;
  logic [STRB_W-1:0] wstrb;
  logic bvalid = 1'b0, bready;
  logic [1:0] bresp = 2'b00;
  logic err;

  int n_chk = 0, n_fail = 0;
  logic [15:0] lfsr = 16'hACE1;
  int exp_addr = 0, exp_len = 0, exp_size = 0;
  int beats = 0, total = 0;
  bit aw_seen = 0, last_seen = 0;
  bit p_awv = 0, p_awr = 0, p_wv = 0, p_wr = 0, p_wl = 0;
  logic [ADDR_W-1:0] p_awaddr = '0;
  logic [DATA_W-1:0] p_wdata = '0;
  logic [STRB_W-1:0] p_wstrb = '0;

  always #5 clk = ~clk;

  axi_wr_burst_master dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_addr_i(cmd_addr), .cmd_len_i(cmd_len), .cmd_size_i(cmd_size),
    .m_awvalid_o(awvalid), .m_awready_i(awready), .m_awaddr_o(awaddr), .m_awlen_o(awlen),
    .m_awsize_o(awsize), .m_awburst_o(awburst), .m_wvalid_o(wvalid), .m_wready_i(wready),
    .m_wdata_o(wdata), .m_wstrb_o(wstrb), .m_wlast_o(wlast), .m_bvalid_i(bvalid),
    .m_bready_o(bready), .m_bresp_i(bresp), .err_o(err));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [STRB_W-1:0] exp_strb(input int addr, input int size, input int k);
    int nb = 1 << size;
    int al = (addr / nb) * nb + k * nb;
    int lo = (k == 0) ? addr % STRB_W : al % STRB_W;
    int hi = al % STRB_W + nb - 1;
    logic [STRB_W-1:0] m = '0;
    for (int i = 0; i < STRB_W; i++) m[i] = (i >= lo) && (i <= hi);
    return m;
  endfunction

  // slave readies with pseudo-random stalls
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    awready = lfsr[0] & lfsr[4];
    wready  = lfsr[5] | lfsr[9];
  end

  // monitor: values here are the ones seen at the next rising edge
  always @(negedge clk) if (rst_ni) begin
    if (p_awv && !p_awr) chk(awvalid && awaddr == p_awaddr, "R4 aw hold", awaddr, p_awaddr);
    if (p_wv && !p_wr)
      chk(wvalid && wdata == p_wdata && wstrb == p_wstrb && wlast == p_wl, "R5 w hold", wdata, p_wdata);
    if (wvalid && last_seen) chk(1'b0, "R6 beat after last", beats, exp_len + 1);
    if (awvalid && awready) aw_seen = 1;
    if (wvalid && wready) begin
      chk(wstrb == exp_strb(exp_addr, exp_size, beats), "R7 strobe", wstrb, exp_strb(exp_addr, exp_size, beats));
      chk(wdata == DATA_W'(total), "R8 data", wdata, total);
      chk(wlast == (beats == exp_len), "R6 last", wlast, beats == exp_len);
      if (wlast) last_seen = 1;
      beats++;
      total++;
    end
    p_awv = awvalid; p_awr = awready; p_awaddr = awaddr;
    p_wv = wvalid; p_wr = wready; p_wdata = wdata; p_wstrb = wstrb; p_wl = wlast;
  end

  task automatic run_burst(input int addr, input int len, input int size, input logic [1:0] resp,
                           input bit exp_err);
    @(posedge clk); #1;
    chk(cmd_ready, "R2 idle ready", cmd_ready, 1);
    exp_addr = addr; exp_len = len; exp_size = size;
    beats = 0; aw_seen = 0; last_seen = 0;
    cmd_valid = 1'b1; cmd_addr = CMD_ADDR_W'(addr); cmd_len = LEN_W'(len); cmd_size = 3'(size);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R2 busy", cmd_ready, 0);
    chk(awvalid && wvalid, "R3 valids raised", {awvalid, wvalid}, 3);
    chk(awaddr == ADDR_W'(addr) && awlen == LEN_W'(len) && awsize == 3'(size) && awburst == 2'b01,
        "R3 aw payload", awaddr, addr);
    while (!(aw_seen && last_seen)) begin
      chk(!bready, "R9 bready early", bready, 0);
      @(posedge clk); #2;
    end
    chk(bready && !cmd_ready, "R9 bready", {bready, cmd_ready}, 2);
    chk(beats == len + 1, "R6 beat count", beats, len + 1);
    bvalid = 1'b1; bresp = resp;
    @(posedge clk); #1;
    bvalid = 1'b0; bresp = 2'b00;
    #1;
    chk(cmd_ready && !bready && !wvalid && !awvalid, "R9 back to idle", cmd_ready, 1);
    chk(err == exp_err, "R10 err flag", err, exp_err);
  endtask

  task automatic reject_cmd(input longint addr, input int size);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_addr = CMD_ADDR_W'(addr); cmd_len = 8'd2; cmd_size = 3'(size);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(!awvalid && !wvalid && cmd_ready, "R11 rejected", {awvalid, wvalid, cmd_ready}, 1);
      @(posedge clk); #1;
    end
  endtask

  initial begin
    for (int i = 0; i < 50000; i++) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!awvalid && !wvalid && !bready && !err && cmd_ready, "R1 reset state",
        {awvalid, wvalid, bready, err, cmd_ready}, 1);
    rst_ni = 1'b1;
    run_burst(32'h0000_1000, 3, 2, 2'b00, 0);   // aligned word burst
    run_burst(32'h0000_1001, 2, 2, 2'b00, 0);   // unaligned first beat 1110
    run_burst(32'h0000_2003, 4, 1, 2'b00, 0);   // halfwords 1000,0011,1100,...
    run_burst(32'h0000_3005, 5, 0, 2'b00, 0);   // bytes rotating lanes
    run_burst(32'h0000_0102, 0, 2, 2'b00, 0);   // single beat, partial 1100
    run_burst(32'h0000_4000, 15, 2, 2'b00, 0);  // longer burst
    reject_cmd(64'h01_0000_0000, 2);            // address beyond ADDR_W
    reject_cmd(64'h0000_5000, 3);               // size wider than bus
    run_burst(32'h0000_6002, 1, 1, 2'b10, 1);   // error response sets err
    run_burst(32'h0000_7000, 2, 2, 2'b00, 1);   // OKAY leaves err set
    @(posedge clk); #1;
    rst_ni = 1'b0;
    #1;
    chk(!err && cmd_ready && !awvalid && !wvalid, "R1 R10 reset clears", err, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule